// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates the interrupt requests of a small 8-bit processor. There are five sources: vertical blank, display status, timer overflow, serial transfer done and keypad falling edge. Each source pulse sets a request flag. The flag stays set until the processor services that source or software overwrites the flag register. A second register holds one enable bit per source. Both registers sit on a two-location register bus, and reads from that bus are combinational.

A global gate, the master enable, decides whether the processor is interrupted at all. The enable and disable commands reach the gate only when the instruction after them completes. The return-and-enable command opens the gate at once. When the processor acknowledges a request, the block presents a fixed vector for the highest-priority pending and enabled source. On that acknowledge it clears the flag of that source and closes the master gate. A wake output tells a halted core that some enabled request is pending, whatever the state of the gate.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, the master gate is closed, and `irq_req`, `wake` and `irq_vector` are all 0.
- R2: A one-cycle high on `src_pulse[i]` sets request flag i on the next clock, and the flag stays set. The bit map is 0 vertical blank, 1 display status, 2 timer, 3 serial, 4 keypad.
- R3: With `bus_sel`=0 the bus reaches the request flags, and with `bus_sel`=1 it reaches the enables. A write with `bus_we` takes effect on the next clock. Only bits 4:0 are stored, and bits 7:5 always read 0.
- R4: When a source pulse and a flag-register write come in the same cycle, the pulsed bit ends up set, whatever value is written.
- R5: `irq_req` is high exactly when the master gate is open and at least one source has both its flag and its enable set.
- R6: `irq_vector` equals 0x0040 + 8*i, where i is the lowest-numbered source that has both flag and enable set, so bit 0 has the highest priority. It is 0x0000 when no such source exists.
- R7: An `irq_ack` while `irq_req` is high clears only the flag of the source being serviced, and closes the master gate on the next clock.
- R8: The enable command (`cmd_ei` with `instr_done`) opens the gate only on the next `instr_done` after it.
- R9: The disable command (`cmd_di` with `instr_done`) closes the gate only on the next `instr_done` after it. Until then, requests are still raised.
- R10: `cmd_reti` opens the master gate on the next clock, with no delay of one instruction.
- R11: `wake` is high whenever some source has both flag and enable set, including while the master gate is closed.
- R12: If a source pulses in the same cycle that its own request is acknowledged, its flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 5 | One-cycle request pulses, one per source |
| bus_sel | input | 1 | Register select: 0 request flags, 1 enables |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| instr_done | input | 1 | An instruction completes this cycle |
| cmd_ei | input | 1 | The completing instruction is the enable command |
| cmd_di | input | 1 | The completing instruction is the disable command |
| cmd_reti | input | 1 | Return-and-enable: open the gate now |
| irq_ack | input | 1 | Processor accepts the current request |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vector | output | 16 | Service address of the winning source |
| wake | output | 1 | Some enabled request is pending |

## Verification
Corrupted flag or enable state shows on the bus read and on `irq_vector` and `wake` in the same cycle. That is why every one of the 32 flag patterns is written and then checked against several enable masks. A wrong master-gate state is visible only through `irq_req`. The gate is therefore probed at the cycle just after each command and after each `instr_done`, where a delay lost or added would show as an early or late request. A flag not cleared on service shows as the same vector being served again after the return-and-enable.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Pending change to the master gate, waiting for the next instruction
   typedef enum logic [1:0] {
      ARM_NONE = 2'd0,
      ARM_OPEN = 2'd1,
      ARM_SHUT = 2'd2
   } gate_arm_t;

   // Register-bus select codes
   localparam logic SEL_FLAGS  = 1'b0;
   localparam logic SEL_ENABLE = 1'b1;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N_SRC = 5,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_pulse,
   input  logic             wr_flags,
   input  logic             wr_enables,
   input  logic [BUS_W-1:0] wdata,
   input  logic [N_SRC-1:0] svc_clr,
   output logic [N_SRC-1:0] flags,
   output logic [N_SRC-1:0] enables
);

   generate
      if (N_SRC < 1 || N_SRC > BUS_W) begin : g_bad_width
         $error("irq_flag_bank: N_SRC must lie in 1..BUS_W");
      end
   endgenerate

   logic [N_SRC-1:0] en_q;

   // One storage cell per source; priority: pulse, then service clear, then write
   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_cell
         logic cell_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cell_q <= 1'b0;
            end else if (src_pulse[i]) begin
               cell_q <= 1'b1;
            end else if (svc_clr[i]) begin
               cell_q <= 1'b0;
            end else if (wr_flags) begin
               cell_q <= wdata[i];
            end
         end

         assign flags[i] = cell_q;

         // R2
         pulse_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[i] |=> flags[i]);

         // R7
         svc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_clr[i] && !src_pulse[i]) |=> !flags[i]);

         // R2
         flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !svc_clr[i] && !wr_flags) |=> flags[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_enables) begin
         en_q <= wdata[N_SRC-1:0];
      end
   end

   assign enables = en_q;

   // R3
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enables |=> (enables == $past(wdata[N_SRC-1:0])));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N_SRC      = 5,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 'h40,
   parameter int VEC_STRIDE = 8,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic [N_SRC-1:0] pending,
   output logic [N_SRC-1:0] grant,
   output logic             any,
   output logic [VEC_W-1:0] vector
);

   localparam int IDX_W   = irq_pkg::idx_width(N_SRC);
   localparam int TOP_VEC = VEC_BASE + (N_SRC - 1) * VEC_STRIDE;

   generate
      if (VEC_STRIDE < 1) begin : g_bad_stride
         $error("irq_prio_enc: VEC_STRIDE must be positive");
      end
      if (TOP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_prio_enc: highest vector does not fit VEC_W");
      end
   endgenerate

   logic [IDX_W-1:0] win_idx;
   logic             hit;

   generate
      if (LOW_FIRST) begin : g_low_first
         // Scan downward so the lowest set bit is the last one written
         always_comb begin
            win_idx = '0;
            hit     = 1'b0;
            for (int i = N_SRC - 1; i >= 0; i--) begin
               if (pending[i]) begin
                  win_idx = IDX_W'(i);
                  hit     = 1'b1;
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            win_idx = '0;
            hit     = 1'b0;
            for (int i = 0; i < N_SRC; i++) begin
               if (pending[i]) begin
                  win_idx = IDX_W'(i);
                  hit     = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      grant = '0;
      if (hit) begin
         grant[win_idx] = 1'b1;
      end
   end

   assign any    = hit;
   assign vector = hit ? VEC_W'(VEC_BASE + int'(win_idx) * VEC_STRIDE) : '0;

endmodule

// File: rtl/irq_master_gate.sv
module irq_master_gate
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic instr_done,
   input  logic cmd_ei,
   input  logic cmd_di,
   input  logic cmd_reti,
   input  logic svc_ack,
   output logic gate_open
);

   gate_arm_t arm_q, arm_d;
   logic      open_q, open_d;

   always_comb begin
      arm_d  = arm_q;
      open_d = open_q;
      if (svc_ack) begin
         open_d = 1'b0;
         arm_d  = ARM_NONE;
      end else if (cmd_reti) begin
         open_d = 1'b1;
         arm_d  = ARM_NONE;
      end else if (instr_done) begin
         // Apply what the previous instruction armed, then arm the new command
         if (arm_q == ARM_OPEN) begin
            open_d = 1'b1;
         end else if (arm_q == ARM_SHUT) begin
            open_d = 1'b0;
         end
         if (cmd_ei) begin
            arm_d = ARM_OPEN;
         end else if (cmd_di) begin
            arm_d = ARM_SHUT;
         end else begin
            arm_d = ARM_NONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= ARM_NONE;
         open_q <= 1'b0;
      end else begin
         arm_q  <= arm_d;
         open_q <= open_d;
      end
   end

   assign gate_open = open_q;

   // R7
   ack_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_ack |=> !gate_open);

   // R8
   open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_open) |-> ($past(cmd_reti) || ($past(instr_done) && $past(arm_q == ARM_OPEN))));

   // R9
   di_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && cmd_di && gate_open && arm_q != ARM_SHUT && !svc_ack && !cmd_reti)
      |=> gate_open);

   // R8
   ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_done && cmd_ei && !gate_open && arm_q != ARM_OPEN && !cmd_reti)
      |=> !gate_open);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC      = 5,
   parameter int BUS_W      = 8,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 'h40,
   parameter int VEC_STRIDE = 8,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_pulse,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             instr_done,
   input  logic             cmd_ei,
   input  logic             cmd_di,
   input  logic             cmd_reti,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vector,
   output logic             wake
);
   import irq_pkg::*;

   localparam int PAD_W = BUS_W - N_SRC;

   logic [N_SRC-1:0] flags, enables, pending, grant, svc_clr;
   logic             any_pend, gate_open, svc_ack;
   logic             wr_flags, wr_enables;
   logic [N_SRC-1:0] sel_word;

   assign wr_flags   = bus_we && (bus_sel == SEL_FLAGS);
   assign wr_enables = bus_we && (bus_sel == SEL_ENABLE);

   irq_flag_bank #(.N_SRC(N_SRC), .BUS_W(BUS_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_pulse  (src_pulse),
      .wr_flags   (wr_flags),
      .wr_enables (wr_enables),
      .wdata      (bus_wdata),
      .svc_clr    (svc_clr),
      .flags      (flags),
      .enables    (enables)
   );

   assign pending = flags & enables;

   irq_prio_enc #(
      .N_SRC      (N_SRC),
      .VEC_W      (VEC_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE),
      .LOW_FIRST  (LOW_FIRST)
   ) u_enc (
      .pending (pending),
      .grant   (grant),
      .any     (any_pend),
      .vector  (irq_vector)
   );

   irq_master_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_done (instr_done),
      .cmd_ei     (cmd_ei),
      .cmd_di     (cmd_di),
      .cmd_reti   (cmd_reti),
      .svc_ack    (svc_ack),
      .gate_open  (gate_open)
   );

   assign irq_req = gate_open && any_pend;
   assign svc_ack = irq_ack && irq_req;
   assign svc_clr = grant & {N_SRC{svc_ack}};
   assign wake    = any_pend;

   assign sel_word = (bus_sel == SEL_ENABLE) ? enables : flags;

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata = {{PAD_W{1'b0}}, sel_word};
      end else begin : g_nopad
         assign bus_rdata = sel_word;
      end
   endgenerate

   // R6
   grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6
   grant_in_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~pending) == '0);

   // R10
   reti_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_reti && !svc_ack) |=> gate_open);

   // R12
   pulse_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ack && ((src_pulse & grant) != '0)) |=> ((flags & $past(grant)) != '0));

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_pulse = '0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        instr_done = 1'b0;
   logic        cmd_ei = 1'b0;
   logic        cmd_di = 1'b0;
   logic        cmd_reti = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [15:0] irq_vector;
   logic        wake;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_pulse  (src_pulse),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .instr_done (instr_done),
      .cmd_ei     (cmd_ei),
      .cmd_di     (cmd_di),
      .cmd_reti   (cmd_reti),
      .irq_ack    (irq_ack),
      .irq_req    (irq_req),
      .irq_vector (irq_vector),
      .wake       (wake)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Inputs driven 1 ns after a rising edge; consumed at the next rising edge
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic bus_write(input logic sel, input logic [7:0] data);
      bus_sel   = sel;
      bus_wdata = data;
      bus_we    = 1'b1;
      step();
      bus_we    = 1'b0;
   endtask

   task automatic read_reg(input logic sel, output logic [7:0] val);
      bus_sel = sel;
      #1;
      val = bus_rdata;
   endtask

   task automatic retire(input logic ei, input logic di);
      instr_done = 1'b1;
      cmd_ei     = ei;
      cmd_di     = di;
      step();
      instr_done = 1'b0;
      cmd_ei     = 1'b0;
      cmd_di     = 1'b0;
   endtask

   function automatic logic [15:0] exp_vec(input logic [4:0] p);
      for (int i = 0; i < 5; i++) begin
         if (p[i]) return 16'h0040 + 16'(8 * i);
      end
      return 16'h0000;
   endfunction

   // Watchdog
   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      logic [4:0] en_set [3];
      en_set[0] = 5'h1F;
      en_set[1] = 5'h15;
      en_set[2] = 5'h0A;

      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step();

      // R1 reset state
      read_reg(1'b0, rv);
      check("R1 flags", 16'(rv), 16'h00);
      read_reg(1'b1, rv);
      check("R1 enables", 16'(rv), 16'h00);
      check("R1 irq_req", 16'(irq_req), 16'h0);
      check("R1 wake", 16'(wake), 16'h0);
      check("R1 vector", irq_vector, 16'h0000);

      // R3 upper bits not stored
      bus_write(1'b1, 8'hFF);
      read_reg(1'b1, rv);
      check("R3 enable upper bits", 16'(rv), 16'h1F);
      bus_write(1'b0, 8'hE0);
      read_reg(1'b0, rv);
      check("R3 flag upper bits", 16'(rv), 16'h00);

      // R6 R11 R5 sweep with master gate closed
      for (int e = 0; e < 3; e++) begin
         bus_write(1'b1, {3'b000, en_set[e]});
         for (int f = 0; f < 32; f++) begin
            bus_write(1'b0, 8'(f));
            read_reg(1'b0, rv);
            check("R3 flag readback", 16'(rv), 16'(f));
            check("R6 vector", irq_vector, exp_vec(5'(f) & en_set[e]));
            check("R11 wake gate closed", 16'(wake), 16'(|(5'(f) & en_set[e])));
            check("R5 no req gate closed", 16'(irq_req), 16'h0);
         end
      end

      // R8 delayed enable
      bus_write(1'b1, 8'h1F);
      bus_write(1'b0, 8'h04);
      retire(1'b1, 1'b0);
      check("R8 not open after ei", 16'(irq_req), 16'h0);
      retire(1'b0, 1'b0);
      check("R8 open after next instr", 16'(irq_req), 16'h1);

      // R5 sweep with gate open
      for (int e = 0; e < 3; e++) begin
         bus_write(1'b1, {3'b000, en_set[e]});
         for (int f = 0; f < 32; f++) begin
            bus_write(1'b0, 8'(f));
            check("R5 req gate open", 16'(irq_req), 16'(|(5'(f) & en_set[e])));
         end
      end

      // R9 delayed disable
      bus_write(1'b1, 8'h1F);
      bus_write(1'b0, 8'h10);
      retire(1'b0, 1'b1);
      check("R9 still open after di", 16'(irq_req), 16'h1);
      retire(1'b0, 1'b0);
      check("R9 shut after next instr", 16'(irq_req), 16'h0);
      check("R11 wake after di", 16'(wake), 16'h1);

      // R10 immediate return-and-enable, R7 service sequence
      bus_write(1'b0, 8'h1F);
      cmd_reti = 1'b1;
      step();
      cmd_reti = 1'b0;
      check("R10 reti opens", 16'(irq_req), 16'h1);
      for (int k = 0; k < 5; k++) begin
         check("R6 served vector", irq_vector, 16'h0040 + 16'(8 * k));
         irq_ack = 1'b1;
         step();
         irq_ack = 1'b0;
         read_reg(1'b0, rv);
         check("R7 only served flag cleared", 16'(rv), 16'(5'h1F & ~5'((1 << (k + 1)) - 1)));
         check("R7 gate shut on ack", 16'(irq_req), 16'h0);
         check("R11 wake after ack", 16'(wake), 16'(k < 4));
         cmd_reti = 1'b1;
         step();
         cmd_reti = 1'b0;
         check("R10 reti reopens", 16'(irq_req), 16'(k < 4));
      end

      // R12 pulse coincident with its own ack
      bus_write(1'b0, 8'h02);
      check("R12 req before", 16'(irq_req), 16'h1);
      irq_ack   = 1'b1;
      src_pulse = 5'h02;
      step();
      irq_ack   = 1'b0;
      src_pulse = 5'h00;
      read_reg(1'b0, rv);
      check("R12 flag kept", 16'(rv), 16'h02);
      check("R7 gate shut", 16'(irq_req), 16'h0);

      // R2 latch of each source pulse, R4 pulse over write
      bus_write(1'b0, 8'h00);
      for (int i = 0; i < 5; i++) begin
         src_pulse = 5'(1 << i);
         step();
         src_pulse = 5'h00;
         step();
         read_reg(1'b0, rv);
         check("R2 latched and held", 16'(rv), 16'((1 << (i + 1)) - 1));
      end
      bus_sel   = 1'b0;
      bus_wdata = 8'h00;
      bus_we    = 1'b1;
      src_pulse = 5'h08;
      step();
      bus_we    = 1'b0;
      src_pulse = 5'h00;
      read_reg(1'b0, rv);
      check("R4 pulse beats write", 16'(rv), 16'h08);
      check("R6 vector after R4", irq_vector, 16'h0058);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule